// File: doc/BRIEF.md
# Shared Crypto Engine Pool Allocator

This block hands out a pool of identical AES engines to two traffic directions: the receive stream, which decrypts data arriving from storage, and the transmit stream, which encrypts data going out. Without it the pool is split in a fixed way, so half of the engines sit idle whenever only one direction is moving data. In shared mode the engines follow the traffic: a read-only phase gives all of them to receive, a write-only phase gives all of them to transmit, and concurrent traffic splits them by a programmed ratio.

Software programs two registers once, after the host controller has finished its enable sequence and only when crypto is on. One register selects shared or fixed allocation. The other holds four packed byte counts, one for each activity case. The traffic side drives one activity flag per stream and one busy flag per engine. The block returns an ownership code for each engine and the number of engines each direction holds at present. An engine that has to change owner in the middle of a data block keeps its old owner until that block ends.

Top module: `shared_pool_alloc`

## Requirements
- R1: After reset the mode register reads 0 and the count register reads 0x0D0F1C1C. Engines 0 to 13 belong to receive and engines 14 to 27 belong to transmit.
- R2: A read of offset 0x260C or 0x2664 returns the last value written there. A read of any other offset returns 0. A write to any other offset changes neither register.
- R3: Shared allocation is active only while the mode register holds exactly 2. Any other value selects the fixed split.
- R4: In the fixed split, engines below index 14 are receive and the rest are transmit. Both counts are 14 whatever the activity flags are.
- R5: In shared mode with only rdActive high, receive gets the count in bits 7:0 of the count register and transmit gets none.
- R6: In shared mode with only wrActive high, transmit gets the count in bits 15:8 and receive gets none.
- R7: In shared mode with both flags high, receive gets the count in bits 23:16 and transmit gets the count in bits 31:24.
- R8: In shared mode with neither flag high, every engine that is not busy becomes unassigned. With no engine busy, both counts are 0.
- R9: A field value above 28 is treated as 28. In the concurrent case, if the two counts add up to more than 28, the transmit count is lowered so that the total is 28.
- R10: Receive takes the engines with the lowest indices and transmit takes those with the highest. The ownership code of engine i is at engOwner[2i+1:2i]: 0 means unassigned, 1 receive, 2 transmit.
- R11: An engine whose engBusy bit is high keeps its current owner. It takes its new owner in the cycle after the bit goes low, and it counts only for the owner it actually has.
- R12: Ownership and both counts reflect inputs and register contents one clock edge after the edge that samples them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 16 | Register offset for reads and writes |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| rdActive | input | 1 | A receive data block is in progress |
| wrActive | input | 1 | A transmit data block is in progress |
| engBusy | input | 28 | Per-engine flag: the engine is in the middle of a block |
| engOwner | output | 56 | Two-bit ownership code per engine |
| rxCount | output | 5 | Number of engines owned by receive |
| txCount | output | 5 | Number of engines owned by transmit |

## Verification
Two functions can act in the same cycle: a change in stream activity that moves engines to the other owner, and an engine's busy flag holding its old owner. The bench makes them meet by raising engBusy on a group of receive engines and then switching to concurrent traffic, which puts some of those engines in transmit territory. On the next edge the held engines must keep the receive code and still count as receive, while the idle ones move. Once the busy bits drop, a bench model that tracks each engine on its own must agree with the design on every ownership code and on both counts.

// File: rtl/pool_alloc_pkg.sv
package pool_alloc_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_RX   = 2'd1,
    OWN_TX   = 2'd2
  } owner_e;

  // engine quotas handed from control to datapath
  typedef struct packed {
    logic [7:0] rxNum;
    logic [7:0] txNum;
  } plan_t;

  localparam logic [31:0] COUNT_RESET = {8'd13, 8'd15, 8'd28, 8'd28};
  localparam logic [31:0] SHARED_CODE = 32'd2;
endpackage

// File: rtl/pool_alloc_ctrl.sv
module pool_alloc_ctrl
  import pool_alloc_pkg::*;
#(
  parameter int NUM_ENG = 28,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 16'h260C,
  parameter logic [ADDR_W-1:0] COUNT_ADDR = 16'h2664
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              rdActive,
  input  logic              wrActive,
  output plan_t             plan
);
  localparam int HALF = NUM_ENG / 2;
  localparam logic [7:0] ENG8 = 8'(NUM_ENG);
  localparam logic [7:0] HALF8 = 8'(HALF);

  logic [31:0] modeReg;
  logic [31:0] countReg;
  logic        isShared;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= '0;
      countReg <= COUNT_RESET;
    end else if (regWrEn) begin
      if (regAddr == MODE_ADDR)  modeReg  <= regWrData;
      if (regAddr == COUNT_ADDR) countReg <= regWrData;
    end
  end

  always_comb begin
    if (regAddr == MODE_ADDR)       regRdData = modeReg;
    else if (regAddr == COUNT_ADDR) regRdData = countReg;
    else                            regRdData = '0;
  end

  function automatic logic [7:0] clampEng(input logic [7:0] v);
    return (v > ENG8) ? ENG8 : v;
  endfunction

  assign isShared = (modeReg == SHARED_CODE);

  logic [7:0] bothRx, bothTx;
  logic [8:0] bothSum;

  always_comb begin
    bothRx  = clampEng(countReg[23:16]);
    bothTx  = clampEng(countReg[31:24]);
    bothSum = {1'b0, bothRx} + {1'b0, bothTx};
    if (bothSum > {1'b0, ENG8}) bothTx = ENG8 - bothRx;
  end

  always_comb begin
    if (!isShared) begin
      plan.rxNum = HALF8;
      plan.txNum = ENG8 - HALF8;
    end else begin
      unique case ({rdActive, wrActive})
        2'b10:   begin plan.rxNum = clampEng(countReg[7:0]); plan.txNum = '0; end
        2'b01:   begin plan.rxNum = '0; plan.txNum = clampEng(countReg[15:8]); end
        2'b11:   begin plan.rxNum = bothRx; plan.txNum = bothTx; end
        default: begin plan.rxNum = '0; plan.txNum = '0; end
      endcase
    end
  end

  // R2: writes to unmapped offsets leave both registers untouched
  p_unmapped_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr != MODE_ADDR && regAddr != COUNT_ADDR)
      |=> ($stable(modeReg) && $stable(countReg)));

  // R4: a non-shared mode value yields the fixed split whatever the activity
  p_static_split_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == MODE_ADDR && regWrData != SHARED_CODE)
      |=> (plan.rxNum == HALF8 && plan.txNum == ENG8 - HALF8));

  // R9: the quota never exceeds the pool
  p_quota_fits_r9: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, plan.rxNum} + {1'b0, plan.txNum}) <= {1'b0, ENG8});
endmodule

// File: rtl/pool_alloc_datapath.sv
module pool_alloc_datapath
  import pool_alloc_pkg::*;
#(
  parameter int NUM_ENG = 28,
  parameter int CNT_W = $clog2(NUM_ENG + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  plan_t                plan,
  input  logic [NUM_ENG-1:0]   engBusy,
  output logic [2*NUM_ENG-1:0] engOwner,
  output logic [CNT_W-1:0]     rxCount,
  output logic [CNT_W-1:0]     txCount
);
  localparam int HALF = NUM_ENG / 2;

  owner_e ownerQ [NUM_ENG];
  owner_e target [NUM_ENG];

  for (genvar i = 0; i < NUM_ENG; i++) begin : g_eng
    localparam owner_e RST_OWN = (i < HALF) ? OWN_RX : OWN_TX;

    always_comb begin
      if (9'(i) < {1'b0, plan.rxNum})
        target[i] = OWN_RX;
      else if (9'(i) >= 9'(NUM_ENG) - {1'b0, plan.txNum})
        target[i] = OWN_TX;
      else
        target[i] = OWN_NONE;
    end

    always_ff @(posedge clk) begin
      if (!rstN)           ownerQ[i] <= RST_OWN;
      else if (!engBusy[i]) ownerQ[i] <= target[i];
    end

    assign engOwner[2*i +: 2] = ownerQ[i];

    // R11: a busy engine keeps its owner across the edge
    p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rstN)
      engBusy[i] |=> (ownerQ[i] == $past(ownerQ[i])));
  end

  always_comb begin
    rxCount = '0;
    txCount = '0;
    for (int k = 0; k < NUM_ENG; k++) begin
      if (ownerQ[k] == OWN_RX) rxCount = rxCount + CNT_W'(1);
      if (ownerQ[k] == OWN_TX) txCount = txCount + CNT_W'(1);
    end
  end

  // R10: the two sets stay disjoint, so their sizes fit in the pool
  p_counts_fit_r10: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, rxCount} + {1'b0, txCount}) <= (CNT_W + 1)'(NUM_ENG));

  // R8: an empty quota with no busy engine leaves both counts at zero
  p_idle_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    (plan.rxNum == 8'd0 && plan.txNum == 8'd0 && engBusy == '0)
      |=> (rxCount == '0 && txCount == '0));
endmodule

// File: rtl/shared_pool_alloc.sv
module shared_pool_alloc
  import pool_alloc_pkg::*;
#(
  parameter int NUM_ENG = 28,
  parameter int ADDR_W = 16,
  parameter int CNT_W = $clog2(NUM_ENG + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic                 rdActive,
  input  logic                 wrActive,
  input  logic [NUM_ENG-1:0]   engBusy,
  output logic [2*NUM_ENG-1:0] engOwner,
  output logic [CNT_W-1:0]     rxCount,
  output logic [CNT_W-1:0]     txCount
);
  plan_t plan;

  pool_alloc_ctrl #(.NUM_ENG(NUM_ENG), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .rdActive(rdActive), .wrActive(wrActive), .plan(plan)
  );

  pool_alloc_datapath #(.NUM_ENG(NUM_ENG), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .plan(plan), .engBusy(engBusy),
    .engOwner(engOwner), .rxCount(rxCount), .txCount(txCount)
  );
endmodule

// File: tb/tb_shared_pool_alloc.sv
`timescale 1ns/1ps
module tb_shared_pool_alloc;
  localparam int N = 28;
  localparam logic [15:0] MODE_A = 16'h260C;
  localparam logic [15:0] CNT_A = 16'h2664;

  logic clk = 0, rstN = 0, regWrEn = 0, rdActive = 0, wrActive = 0;
  logic [15:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic [N-1:0] engBusy = '0;
  logic [2*N-1:0] engOwner;
  logic [4:0] rxCount, txCount;

  int checks = 0, fails = 0;
  int expOwn [N];
  logic [31:0] modeV, cntV;

  always #2.5 clk = ~clk;

  shared_pool_alloc dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .rdActive(rdActive),
    .wrActive(wrActive), .engBusy(engBusy), .engOwner(engOwner),
    .rxCount(rxCount), .txCount(txCount)
  );

  function automatic int clampN(int v);
    return (v > N) ? N : v;
  endfunction

  // quota from the requirements (R3..R9)
  task automatic quota(output int rx, output int tx);
    if (modeV != 32'd2) begin rx = 14; tx = 14; end
    else if (rdActive && !wrActive) begin rx = clampN(int'(cntV[7:0])); tx = 0; end
    else if (!rdActive && wrActive) begin rx = 0; tx = clampN(int'(cntV[15:8])); end
    else if (rdActive && wrActive) begin
      rx = clampN(int'(cntV[23:16])); tx = clampN(int'(cntV[31:24]));
      if (rx + tx > N) tx = N - rx;
    end else begin rx = 0; tx = 0; end
  endtask

  // one clock edge: model follows R10/R11, then move to the next low phase
  task automatic step();
    int rx, tx;
    quota(rx, tx);
    for (int i = 0; i < N; i++)
      if (!engBusy[i]) expOwn[i] = (i < rx) ? 1 : ((i >= N - tx) ? 2 : 0);
    @(negedge clk);
  endtask

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    int rxE = 0, txE = 0;
    logic [2*N-1:0] vec;
    for (int i = 0; i < N; i++) begin
      vec[2*i +: 2] = 2'(expOwn[i]);
      if (expOwn[i] == 1) rxE++;
      if (expOwn[i] == 2) txE++;
    end
    checks++;
    if (engOwner !== vec) begin
      fails++;
      $display("FAIL %s owners: actual %h expected %h", tag, engOwner, vec);
    end
    cmp({tag, " rxCount"}, int'(rxCount), rxE);
    cmp({tag, " txCount"}, int'(txCount), txE);
  endtask

  task automatic writeReg(logic [15:0] a, logic [31:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    step();
    if (a == MODE_A) modeV = d;
    if (a == CNT_A) cntV = d;
    regWrEn = 0;
  endtask

  task automatic readChk(string tag, logic [15:0] a, logic [31:0] exp);
    regAddr = a;
    #0.5;
    checks++;
    if (regRdData !== exp) begin
      fails++;
      $display("FAIL %s read %h: actual %h expected %h", tag, a, regRdData, exp);
    end
  endtask

  task automatic sweepAct(string tag);
    for (int c = 0; c < 4; c++) begin
      rdActive = c[1]; wrActive = c[0];
      step();
      step();
      checkAll(tag);
    end
  endtask

  initial begin : watchdog
    #500us;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    int cfgs [5];
    modeV = 0; cntV = 32'h0D0F1C1C;
    for (int i = 0; i < N; i++) expOwn[i] = (i < 14) ? 1 : 2;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    checkAll("R1");
    readChk("R1", MODE_A, 32'h0);
    readChk("R1", CNT_A, 32'h0D0F1C1C);

    // R2: readback, unmapped read returns zero, unmapped write ignored
    writeReg(16'h2660, 32'hFFFF_FFFF);
    writeReg(16'h0000, 32'h1234_5678);
    readChk("R2", MODE_A, 32'h0);
    readChk("R2", CNT_A, 32'h0D0F1C1C);
    readChk("R2", 16'h2660, 32'h0);

    // R4: fixed split under every activity pattern
    sweepAct("R4");

    cfgs[0] = 32'h0D0F1C1C; // defaults: R5 R6 R7 R8
    cfgs[1] = 32'h04030705; // small counts, R10 placement
    cfgs[2] = 32'h1414_1E28; // above 28 and overflowing sum, R9
    cfgs[3] = 32'h001C0000; // rx takes all in concurrent case, R9
    cfgs[4] = 32'h051BC80A; // 200 clamped, 27+5 reduced, R9
    for (int m = 0; m < 3; m++) begin
      // R3: mode 2 shared, 0 and 3 fixed
      writeReg(MODE_A, (m == 0) ? 32'd2 : ((m == 1) ? 32'd3 : 32'd0));
      readChk("R3", MODE_A, modeV);
      for (int k = 0; k < 5; k++) begin
        writeReg(CNT_A, cfgs[k]);
        readChk("R2", CNT_A, cfgs[k]);
        sweepAct((m == 0) ? "R5-R9 R12 shared" : "R3 R4 fixed");
      end
    end

    // R11: busy engines hold while activity moves them
    writeReg(MODE_A, 32'd2);
    writeReg(CNT_A, 32'h0D0F1C1C);
    rdActive = 1; wrActive = 0;
    step(); step();
    checkAll("R5 before busy");
    engBusy = 28'hFF0_000F;   // engines 0..3 and 20..27 busy
    rdActive = 1; wrActive = 1;
    step();
    checkAll("R11 held");
    rdActive = 0; wrActive = 0;
    step();
    checkAll("R11 R8 busy while idle");
    engBusy = '0;
    step();
    checkAll("R11 released R8");
    rdActive = 0; wrActive = 1;
    engBusy = 28'h000_0003;
    step();
    checkAll("R11 R6 partial");
    engBusy = '0;
    step();
    checkAll("R12 R6 after release");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule